// File: doc/BRIEF.md
# Halt-Aware Trace Timestamp Counter

This block is the global time base for trace data. A wide binary counter advances by one on every clock while trace capture is switched on. A configuration bit can make the count stop while the processor core is in debug halt. Trace logic elsewhere reads the count and stamps it into its packets. A one-cycle pulse marks each rollover, so downstream logic can extend the time base if it needs to.

The configuration bit comes in as a plain level from a control register that lives outside this block. The block captures that level in its own flop, which a synchronous reset clears. The count is split into equal slices joined by a ripple carry. Each slice is a small incrementer, which keeps the logic depth per clock short for the wide default.

Top module: `trace_tstamp_top`

## Requirements
- R1: While `rst_i` is high at a clock edge, the count goes to zero, the wrap pulse goes low and the captured freeze setting goes to 0. As a result, the first edge after reset advances the count even if `freeze_req_i` and `core_halted_i` are both high.
- R2: With `trace_en_i` high and no freeze in force, the count increases by exactly one at every clock edge.
- R3: With `trace_en_i` low, the count holds its value, whatever the halt and freeze inputs are.
- R4: With the captured freeze setting at 0, the count keeps advancing while `core_halted_i` is high.
- R5: With the captured freeze setting at 1 and `core_halted_i` high, the count holds its value.
- R6: When `core_halted_i` drops, the first clock edge that sees it low advances the count from the held value, not from zero.
- R7: `freeze_req_i` is captured at each clock edge. A change made before edge k governs the count from edge k+1 on, whether the change sets or clears the setting.
- R8: When the count is at its all-ones value and advances, it becomes zero. `wrap_o` is high for exactly that one cycle, alongside the zero count. A count that is held at all-ones raises no pulse.
- R9: The count is `CNT_W` bits wide (48 by default). A carry passes between slices in the same edge, so the full-width value always increments as a single binary number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| trace_en_i | input | 1 | Trace capture enabled; the count may advance only while this is high |
| core_halted_i | input | 1 | Core is in debug halt |
| freeze_req_i | input | 1 | Configuration level: freeze the count during debug halt when 1 |
| ts_o | output | CNT_W | Current timestamp value |
| wrap_o | output | 1 | One-cycle pulse in the cycle the count shows zero after rolling over |

## Verification
The bench uses an 8-bit counter made of two 4-bit slices, so a full rollover and every carry between slices fall inside a short run. A missing carry from the low slice would show up as a jump back from 0x0F to 0x00.

The bench parks the count at all-ones under a halt freeze. A design that derives the pulse from the count value alone, rather than from a real advance, would pulse there. The bench also checks the edge at which the pulse drops.

Other checks cover the following:
- setting and clearing the freeze while halted, where the one-edge capture delay is easy to get wrong in either direction;
- the restart after a halt, which exposes a design that reloads zero;
- a reset applied while freeze and halt are both high, which catches a freeze setting that survives reset.

A long run with random inputs then compares every cycle against an arithmetic model.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    // Registered state of the gating stage.
    typedef struct packed {
        logic frz;
    } tsc_gate_state_t;

    // Registered state of the top level.
    typedef struct packed {
        logic wrap;
    } tsc_top_state_t;

endpackage

// File: rtl/tsc_gate.sv
module tsc_gate
    import tsc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic trace_en_i,
    input  logic core_halted_i,
    input  logic freeze_req_i,
    output logic advance_o,
    output logic freeze_cfg_o
);

    tsc_gate_state_t st_d, st_q;

    // Capture the configuration level every cycle; reset forces it to 0.
    always_comb begin
        st_d     = st_q;
        st_d.frz = freeze_req_i;
        if (rst_i) begin
            st_d.frz = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign freeze_cfg_o = st_q.frz;

    // The count advances when trace is on, unless a freeze is armed and the core is halted.
    assign advance_o = trace_en_i & ~(st_q.frz & core_halted_i);

    // R7: the captured setting follows the request with one edge of delay.
    a_r7_cfg_capture: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(freeze_req_i) |=> freeze_cfg_o);

endmodule

// File: rtl/tsc_slice.sv
module tsc_slice #(
    parameter int SW = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          inc_i,
    output logic [SW-1:0] cnt_o,
    output logic          carry_o
);

    typedef struct packed {
        logic [SW-1:0] cnt;
    } slice_state_t;

    slice_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc_i) begin
            st_d.cnt = st_q.cnt + SW'(1);
        end
        if (rst_i) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign carry_o = inc_i & (&st_q.cnt);

    // R9: each slice steps by one when its carry-in is high and holds otherwise.
    a_r9_slice_step: assert property (@(posedge clk_i) disable iff (rst_i)
        inc_i |=> cnt_o == $past(cnt_o) + SW'(1));
    a_r9_slice_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !inc_i |=> $stable(cnt_o));

endmodule

// File: rtl/trace_tstamp_top.sv
module trace_tstamp_top
    import tsc_pkg::*;
#(
    parameter int CNT_W   = 48,
    parameter int SLICE_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             trace_en_i,
    input  logic             core_halted_i,
    input  logic             freeze_req_i,
    output logic [CNT_W-1:0] ts_o,
    output logic             wrap_o
);

    localparam int N_SLICES = (CNT_W + SLICE_W - 1) / SLICE_W;

    logic                advance;
    logic                freeze_cfg;
    logic [N_SLICES:0]   carry;
    tsc_top_state_t      st_d, st_q;

    tsc_gate u_gate (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .trace_en_i    (trace_en_i),
        .core_halted_i (core_halted_i),
        .freeze_req_i  (freeze_req_i),
        .advance_o     (advance),
        .freeze_cfg_o  (freeze_cfg)
    );

    assign carry[0] = advance;

    // Ripple carry through equal slices; the last slice takes what is left over.
    for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
        localparam int LO     = i * SLICE_W;
        localparam int THIS_W = (CNT_W - LO < SLICE_W) ? (CNT_W - LO) : SLICE_W;

        logic [THIS_W-1:0] part;

        tsc_slice #(.SW(THIS_W)) u_slice (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .inc_i   (carry[i]),
            .cnt_o   (part),
            .carry_o (carry[i+1])
        );

        assign ts_o[LO +: THIS_W] = part;
    end

    // A carry out of the top slice means the full count rolls over to zero at this edge.
    always_comb begin
        st_d      = st_q;
        st_d.wrap = carry[N_SLICES];
        if (rst_i) begin
            st_d.wrap = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign wrap_o = st_q.wrap;

    // R1: reset clears the count, the pulse and the captured setting.
    a_r1_reset: assert property (@(posedge clk_i)
        rst_i |=> (ts_o == '0) && !wrap_o && !freeze_cfg);

    // R2: a full-width step of one when the gate allows it.
    a_r2_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (trace_en_i && !(freeze_cfg && core_halted_i)) |=> ts_o == $past(ts_o) + CNT_W'(1));

    // R3: no movement with trace off.
    a_r3_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        !trace_en_i |=> $stable(ts_o));

    // R5: hold while frozen in halt.
    a_r5_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (freeze_cfg && core_halted_i) |=> $stable(ts_o));

    // R8: the pulse comes with a zero count and lasts one cycle.
    a_r8_wrap_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |-> ts_o == '0);
    a_r8_wrap_single: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> !wrap_o);

endmodule

// File: tb/tb_trace_tstamp_top.sv
module tb_trace_tstamp_top;

    localparam int W  = 8;
    localparam int SW = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         trace_en;
    logic         halted;
    logic         frz_req;
    logic [W-1:0] ts;
    logic         wrap;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model state.
    logic [W-1:0] exp_cnt  = '0;
    logic         exp_wrap = 1'b0;
    logic         exp_frz  = 1'b0;

    always #5 clk = ~clk;

    trace_tstamp_top #(.CNT_W(W), .SLICE_W(SW)) dut (
        .clk_i         (clk),
        .rst_i         (rst),
        .trace_en_i    (trace_en),
        .core_halted_i (halted),
        .freeze_req_i  (frz_req),
        .ts_o          (ts),
        .wrap_o        (wrap)
    );

    // Arithmetic model, evaluated at each rising edge from inputs driven at the falling edge.
    always @(posedge clk) begin
        logic adv;
        if (rst) begin
            exp_cnt  = '0;
            exp_wrap = 1'b0;
            exp_frz  = 1'b0;
        end else begin
            adv      = trace_en && !(exp_frz && halted);
            exp_wrap = adv && (exp_cnt == {W{1'b1}});
            if (adv) exp_cnt = exp_cnt + 1'b1;
            exp_frz  = frz_req;
        end
    end

    task automatic check(input string tag);
        n_chk++;
        if (ts !== exp_cnt || wrap !== exp_wrap) begin
            n_fail++;
            $display("FAIL %s: ts=%0h wrap=%0b expected ts=%0h wrap=%0b",
                     tag, ts, wrap, exp_cnt, exp_wrap);
        end
    endtask

    // One clock: the edge, then compare at the following falling edge.
    task automatic tick(input string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin
        rst = 1'b1; trace_en = 1'b1; halted = 1'b1; frz_req = 1'b1;
        @(negedge clk);
        // R1: reset state, with freeze and halt both requested.
        run(3, "R1");
        rst = 1'b0;
        // R1: the captured setting was cleared, so the first edge advances.
        tick("R1");
        halted = 1'b0; frz_req = 1'b0;
        // R2: plain counting, including the 0x0F to 0x10 crossing (R9).
        run(20, "R2");
        // R3: trace off, with halt and freeze present as well.
        trace_en = 1'b0;
        run(4, "R3");
        halted = 1'b1; frz_req = 1'b1;
        run(4, "R3");
        trace_en = 1'b1; halted = 1'b0; frz_req = 1'b0;
        run(3, "R2");
        // R4: halted, setting 0: keeps counting.
        halted = 1'b1;
        run(8, "R4");
        // R7: set freeze while halted; one more step, then hold (R5).
        frz_req = 1'b1;
        tick("R7");
        run(8, "R5");
        // R6: release halt; resume from the held value.
        halted = 1'b0;
        run(5, "R6");
        // R7: clear freeze while halted; one more held edge, then counting.
        halted = 1'b1;
        run(3, "R5");
        frz_req = 1'b0;
        tick("R7");
        run(4, "R7");
        halted = 1'b0;
        // R9 and R8: several full sweeps with every carry and two rollovers.
        run(600, "R9");
        // R8: park at all-ones under a halt freeze; no pulse while held.
        frz_req = 1'b1;
        while (exp_cnt != {W{1'b1}}) tick("R8");
        halted = 1'b1;
        run(6, "R8");
        halted = 1'b0;
        run(4, "R8");
        // Random mix, checked every cycle against the model.
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            trace_en = (r[1:0] != 2'b00);
            halted   = r[2];
            frz_req  = r[3];
            if (!trace_en) tick("R3");
            else if (exp_frz && halted) tick("R5");
            else if (halted) tick("R4");
            else tick("R2");
        end
        // R1: mid-run reset.
        rst = 1'b1;
        run(2, "R1");
        rst = 1'b0; trace_en = 1'b1; halted = 1'b0;
        run(5, "R2");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule